// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the sync, data-enable and pixel stream for a single display output. A small write port programs it. The horizontal position is counted in pixel clocks within a line. The vertical position is kept as one running pixel-clock count across the whole frame. Every vertical window (sync pulse, displayed region, inner active region, fetch point) is therefore given as an absolute pixel-clock offset inside the frame.

Inside the displayed region the block takes pixels from an upstream stream. An optional inner active window can be enabled separately for the horizontal and vertical directions. Displayed pixels outside that window are filled with a border color. A fixed underflow color is sent when a pixel is due but upstream has none. A one-cycle fetch pulse at a programmed frame offset tells upstream logic to start preparing the next frame. Frame and line counters are visible as outputs.

Timing registers are staged and only take effect at a frame boundary, or at once while the engine is stopped. A single frame never mixes two timing sets.

Top module: `vidtime_engine`

## Requirements
- R1: After reset, and from the second cycle after the engine is disabled, hpos, fpos and both counters are zero, pixel output and fetch are 0, and hsync, vsync and de sit at their inactive level (0 when the matching polarity bit is clear, 1 when it is set).
- R2: Register 0x08 holds the line period in pixel clocks in bits [31:16] and the hsync width in bits [15:0]; hsync is active while hpos < width, and hpos wraps to 0 after period-1.
- R3: Register 0x0C is the frame period in pixel clocks (fpos wraps to 0 after period-1), 0x10 the vsync length in pixel clocks and 0x34 a skew; vsync is active while skew <= fpos < skew+length.
- R4: Register 0x14 holds the last displayed pixel in [31:16] and the first in [15:0], and 0x18 and 0x1C the first and last displayed frame offsets (both inclusive); de is active exactly inside both ranges, and the pixel output is 0 outside them.
- R5: Config register 0x04 bit 29 enables a horizontal active window (0x20, last in [31:16], first in [15:0]) and bit 30 a vertical one (0x24 start, 0x28 end, inclusive); displayed pixels outside an enabled window output the border color of register 0x2C.
- R6: A pixel due inside the active region while pix_in_valid is low outputs the underflow color of register 0x30.
- R7: Register 0x38 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de.
- R8: With config bit 31 set, fetch_o pulses for one cycle each time fpos equals register 0x3C.
- R9: Register 0x40 bit 0 lets the frame counter increment at each fpos wrap, and bit 1 lets the line counter increment at each hpos wrap; the line counter returns to 0 at every fpos wrap.
- R10: Writes to timing, window, color, polarity, skew, fetch and config registers while running take effect on the cycle after the next fpos wrap; while disabled they take effect one cycle after the write.
- R11: pix_in_ready is high in the same cycle that the current position is displayed and inside the active region. All of hsync_o, vsync_o, de_o, pix_out_data and fetch_o are registered, one cycle after that position, and a valid input pixel is passed through unchanged.
- R12: Register 0x00 bit 0 enables the engine, and it and 0x40 act on the cycle after the write. Writes to addresses outside the map are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Register write data |
| pix_in_valid | input | 1 | Upstream pixel present |
| pix_in_data | input | PIX_W | Upstream pixel |
| pix_in_ready | output | 1 | Pixel consumed this cycle |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pix_out_data | output | PIX_W | Output pixel |
| fetch_o | output | 1 | Fetch-start pulse |
| frame_count | output | FCNT_W | Frame counter |
| line_count | output | LCNT_W | Line counter within the frame |

## Verification
A wrong horizontal or frame position shows as an hsync, vsync or de edge in the wrong cycle within one line or one frame. The bench compares every output against its own model on every clock, so such a fault is reported in the first cycle it appears. A staging error (a commit mid-frame or none at all) shows as a changed sync width or window before the fpos wrap, or the old one after it. Counter gating faults show on frame_count and line_count at the first wrap after the enable register changes.

// File: rtl/vidtime_pkg.sv
package vidtime_pkg;

   localparam int REG_W = 32;
   localparam int HW    = 16;
   localparam int VW    = 32;

   localparam logic [7:0] OFF_ENABLE  = 8'h00;
   localparam logic [7:0] OFF_CONFIG  = 8'h04;
   localparam logic [7:0] OFF_LINE    = 8'h08;
   localparam logic [7:0] OFF_FRAME   = 8'h0C;
   localparam logic [7:0] OFF_VPULSE  = 8'h10;
   localparam logic [7:0] OFF_DISP_H  = 8'h14;
   localparam logic [7:0] OFF_DISP_VS = 8'h18;
   localparam logic [7:0] OFF_DISP_VE = 8'h1C;
   localparam logic [7:0] OFF_ACT_H   = 8'h20;
   localparam logic [7:0] OFF_ACT_VS  = 8'h24;
   localparam logic [7:0] OFF_ACT_VE  = 8'h28;
   localparam logic [7:0] OFF_BORDER  = 8'h2C;
   localparam logic [7:0] OFF_UFLOW   = 8'h30;
   localparam logic [7:0] OFF_SKEW    = 8'h34;
   localparam logic [7:0] OFF_POL     = 8'h38;
   localparam logic [7:0] OFF_FETCH   = 8'h3C;
   localparam logic [7:0] OFF_CNT_EN  = 8'h40;

   localparam int CFG_WIN_H_BIT = 29;
   localparam int CFG_WIN_V_BIT = 30;
   localparam int CFG_FETCH_BIT = 31;

   typedef struct packed {
      logic [HW-1:0] h_sync_w;
      logic [HW-1:0] dh_first;
      logic [HW-1:0] dh_last;
      logic [HW-1:0] ah_first;
      logic [HW-1:0] ah_last;
      logic [VW-1:0] v_len;
      logic [VW-1:0] v_skew;
      logic [VW-1:0] dv_first;
      logic [VW-1:0] dv_last;
      logic [VW-1:0] av_first;
      logic [VW-1:0] av_last;
      logic [VW-1:0] fetch_at;
      logic          win_h;
      logic          win_v;
      logic          fetch_en;
      logic [2:0]    pol;
   } win_cfg_t;

endpackage

// File: rtl/vidtime_regs.sv
module vidtime_regs
   import vidtime_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PIX_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              frame_wrap_i,
   output logic              en_o,
   output logic [1:0]        cnt_en_o,
   output logic [HW-1:0]     h_period_o,
   output logic [VW-1:0]     v_period_o,
   output win_cfg_t          cfg_o,
   output logic [PIX_W-1:0]  border_o,
   output logic [PIX_W-1:0]  uflow_o
);

   win_cfg_t          stg_cfg;
   logic [HW-1:0]     stg_hper;
   logic [VW-1:0]     stg_vper;
   logic [PIX_W-1:0]  stg_border;
   logic [PIX_W-1:0]  stg_uflow;
   logic              commit;

   assign commit = !en_o || frame_wrap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o       <= 1'b0;
         cnt_en_o   <= 2'b00;
         stg_cfg    <= '0;
         stg_hper   <= '0;
         stg_vper   <= '0;
         stg_border <= '0;
         stg_uflow  <= '0;
         cfg_o      <= '0;
         h_period_o <= '0;
         v_period_o <= '0;
         border_o   <= '0;
         uflow_o    <= '0;
      end else begin
         if (commit) begin
            cfg_o      <= stg_cfg;
            h_period_o <= stg_hper;
            v_period_o <= stg_vper;
            border_o   <= stg_border;
            uflow_o    <= stg_uflow;
         end
         if (wr_en) begin
            case (wr_addr)
               ADDR_W'(OFF_ENABLE):  en_o <= wr_data[0];
               ADDR_W'(OFF_CNT_EN):  cnt_en_o <= wr_data[1:0];
               ADDR_W'(OFF_CONFIG): begin
                  stg_cfg.win_h    <= wr_data[CFG_WIN_H_BIT];
                  stg_cfg.win_v    <= wr_data[CFG_WIN_V_BIT];
                  stg_cfg.fetch_en <= wr_data[CFG_FETCH_BIT];
               end
               ADDR_W'(OFF_LINE):    {stg_hper, stg_cfg.h_sync_w} <= wr_data;
               ADDR_W'(OFF_FRAME):   stg_vper <= wr_data;
               ADDR_W'(OFF_VPULSE):  stg_cfg.v_len <= wr_data;
               ADDR_W'(OFF_DISP_H):  {stg_cfg.dh_last, stg_cfg.dh_first} <= wr_data;
               ADDR_W'(OFF_DISP_VS): stg_cfg.dv_first <= wr_data;
               ADDR_W'(OFF_DISP_VE): stg_cfg.dv_last <= wr_data;
               ADDR_W'(OFF_ACT_H):   {stg_cfg.ah_last, stg_cfg.ah_first} <= wr_data;
               ADDR_W'(OFF_ACT_VS):  stg_cfg.av_first <= wr_data;
               ADDR_W'(OFF_ACT_VE):  stg_cfg.av_last <= wr_data;
               ADDR_W'(OFF_BORDER):  stg_border <= wr_data[PIX_W-1:0];
               ADDR_W'(OFF_UFLOW):   stg_uflow <= wr_data[PIX_W-1:0];
               ADDR_W'(OFF_SKEW):    stg_cfg.v_skew <= wr_data;
               ADDR_W'(OFF_POL):     stg_cfg.pol <= wr_data[2:0];
               ADDR_W'(OFF_FETCH):   stg_cfg.fetch_at <= wr_data;
               default: ;
            endcase
         end
      end
   end

   // Running engine holds its timing set until the frame wraps (R10)
   assert_hold_midframe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && !frame_wrap_i) |=> (cfg_o == $past(cfg_o) && h_period_o == $past(h_period_o)
                                   && v_period_o == $past(v_period_o)));

endmodule

// File: rtl/vidtime_counters.sv
module vidtime_counters
   import vidtime_pkg::*;
#(
   parameter int LCNT_W = 16,
   parameter int FCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [1:0]        cnt_en_i,
   input  logic [HW-1:0]     h_period_i,
   input  logic [VW-1:0]     v_period_i,
   output logic [HW-1:0]     hpos_o,
   output logic [VW-1:0]     fpos_o,
   output logic              frame_wrap_o,
   output logic [LCNT_W-1:0] line_cnt_o,
   output logic [FCNT_W-1:0] frame_cnt_o
);

   logic [HW:0] h_next;
   logic [VW:0] f_next;
   logic        h_wrap;
   logic        f_wrap;

   assign h_next       = {1'b0, hpos_o} + 1'b1;
   assign f_next       = {1'b0, fpos_o} + 1'b1;
   assign h_wrap       = h_next >= {1'b0, h_period_i};
   assign f_wrap       = f_next >= {1'b0, v_period_i};
   assign frame_wrap_o = en_i && f_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpos_o      <= '0;
         fpos_o      <= '0;
         line_cnt_o  <= '0;
         frame_cnt_o <= '0;
      end else if (!en_i) begin
         hpos_o      <= '0;
         fpos_o      <= '0;
         line_cnt_o  <= '0;
         frame_cnt_o <= '0;
      end else begin
         hpos_o <= h_wrap ? '0 : h_next[HW-1:0];
         fpos_o <= f_wrap ? '0 : f_next[VW-1:0];
         if (f_wrap)
            line_cnt_o <= '0;
         else if (h_wrap && cnt_en_i[1])
            line_cnt_o <= line_cnt_o + 1'b1;
         if (f_wrap && cnt_en_i[0])
            frame_cnt_o <= frame_cnt_o + 1'b1;
      end
   end

   // Stopped engine clears every position and count (R1)
   assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (hpos_o == '0 && fpos_o == '0 && line_cnt_o == '0 && frame_cnt_o == '0));

   // Line count restarts at each frame wrap (R9)
   assert_line_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wrap_o |=> (line_cnt_o == '0 && fpos_o == '0));

   // Frame count never jumps by more than one while running (R9)
   assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> (frame_cnt_o == $past(frame_cnt_o) || frame_cnt_o == $past(frame_cnt_o) + 1'b1));

endmodule

// File: rtl/vidtime_out.sv
module vidtime_out
   import vidtime_pkg::*;
#(
   parameter int PIX_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  win_cfg_t         cfg_i,
   input  logic [PIX_W-1:0] border_i,
   input  logic [PIX_W-1:0] uflow_i,
   input  logic [HW-1:0]    hpos_i,
   input  logic [VW-1:0]    fpos_i,
   input  logic             pix_valid_i,
   input  logic [PIX_W-1:0] pix_data_i,
   output logic             pix_ready_o,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic [PIX_W-1:0] pix_o,
   output logic             fetch_o
);

   localparam int NSYNC = 3;

   logic             in_dh, in_dv, in_disp;
   logic             in_ah, in_av, in_act;
   logic [VW:0]      vs_end;
   logic [NSYNC-1:0] sync_raw;
   logic [NSYNC-1:0] sync_pol;
   logic [PIX_W-1:0] pix_sel;
   logic             fetch_raw;

   assign in_dh   = (hpos_i >= cfg_i.dh_first) && (hpos_i <= cfg_i.dh_last);
   assign in_dv   = (fpos_i >= cfg_i.dv_first) && (fpos_i <= cfg_i.dv_last);
   assign in_disp = en_i && in_dh && in_dv;
   assign in_ah   = !cfg_i.win_h || ((hpos_i >= cfg_i.ah_first) && (hpos_i <= cfg_i.ah_last));
   assign in_av   = !cfg_i.win_v || ((fpos_i >= cfg_i.av_first) && (fpos_i <= cfg_i.av_last));
   assign in_act  = in_ah && in_av;
   assign pix_ready_o = in_disp && in_act;

   assign vs_end      = {1'b0, cfg_i.v_skew} + {1'b0, cfg_i.v_len};
   assign sync_raw[0] = en_i && (hpos_i < cfg_i.h_sync_w);
   assign sync_raw[1] = en_i && (fpos_i >= cfg_i.v_skew) && ({1'b0, fpos_i} < vs_end);
   assign sync_raw[2] = in_disp;
   assign fetch_raw   = en_i && cfg_i.fetch_en && (fpos_i == cfg_i.fetch_at);

   for (genvar i = 0; i < NSYNC; i++) begin : g_pol
      assign sync_pol[i] = sync_raw[i] ^ cfg_i.pol[i];
   end

   always_comb begin
      if (!in_disp)
         pix_sel = '0;
      else if (!in_act)
         pix_sel = border_i;
      else if (pix_valid_i)
         pix_sel = pix_data_i;
      else
         pix_sel = uflow_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {de_o, vsync_o, hsync_o} <= '0;
         pix_o   <= '0;
         fetch_o <= 1'b0;
      end else begin
         {de_o, vsync_o, hsync_o} <= sync_pol;
         pix_o   <= pix_sel;
         fetch_o <= fetch_raw;
      end
   end

   // Outside the displayed region the pixel is blank (R4)
   assert_blank_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_disp |=> pix_o == '0);

   // Displayed but outside the active window gives the border color (R5)
   assert_border_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_disp && !in_act) |=> pix_o == $past(border_i));

   // A due pixel with no upstream data gives the underflow color (R6)
   assert_underflow_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready_o && !pix_valid_i) |=> pix_o == $past(uflow_i));

   // A consumed valid pixel appears unchanged one cycle later (R11)
   assert_passthrough_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready_o && pix_valid_i) |=> pix_o == $past(pix_data_i));

endmodule

// File: rtl/vidtime_engine.sv
module vidtime_engine
   import vidtime_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PIX_W  = 24,
   parameter int LCNT_W = 16,
   parameter int FCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              pix_in_valid,
   input  logic [PIX_W-1:0]  pix_in_data,
   output logic              pix_in_ready,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic [PIX_W-1:0]  pix_out_data,
   output logic              fetch_o,
   output logic [FCNT_W-1:0] frame_count,
   output logic [LCNT_W-1:0] line_count
);

   localparam int MAP_TOP = int'(OFF_CNT_EN);

   if (PIX_W < 1 || PIX_W > REG_W) begin : g_bad_pix
      $error("vidtime_engine: PIX_W must lie in 1..32");
   end
   if (LCNT_W < 1 || LCNT_W > 32 || FCNT_W < 1 || FCNT_W > 32) begin : g_bad_cnt
      $error("vidtime_engine: counter widths must lie in 1..32");
   end
   if ((1 << ADDR_W) <= MAP_TOP || ADDR_W > 16) begin : g_bad_addr
      $error("vidtime_engine: ADDR_W too small for the register map");
   end

   logic          en;
   logic [1:0]    cnt_en;
   logic [HW-1:0] h_period;
   logic [VW-1:0] v_period;
   win_cfg_t      cfg;
   logic [PIX_W-1:0] border, uflow;
   logic [HW-1:0] hpos;
   logic [VW-1:0] fpos;
   logic          frame_wrap;

   vidtime_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .frame_wrap_i(frame_wrap), .en_o(en), .cnt_en_o(cnt_en),
      .h_period_o(h_period), .v_period_o(v_period), .cfg_o(cfg),
      .border_o(border), .uflow_o(uflow)
   );

   vidtime_counters #(.LCNT_W(LCNT_W), .FCNT_W(FCNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(en), .cnt_en_i(cnt_en),
      .h_period_i(h_period), .v_period_i(v_period),
      .hpos_o(hpos), .fpos_o(fpos), .frame_wrap_o(frame_wrap),
      .line_cnt_o(line_count), .frame_cnt_o(frame_count)
   );

   vidtime_out #(.PIX_W(PIX_W)) u_out (
      .clk(clk), .rst_n(rst_n), .en_i(en), .cfg_i(cfg),
      .border_i(border), .uflow_i(uflow), .hpos_i(hpos), .fpos_i(fpos),
      .pix_valid_i(pix_in_valid), .pix_data_i(pix_in_data),
      .pix_ready_o(pix_in_ready), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .de_o(de_o), .pix_o(pix_out_data), .fetch_o(fetch_o)
   );

   // Fetch pulse lasts a single cycle whenever the frame is longer than one clock (R8)
   assert_fetch_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_o && v_period > 1 && en && !frame_wrap) |=> !fetch_o);

endmodule

// File: tb/vidtime_engine_tb.sv
module vidtime_engine_tb;

   localparam int PIX_W = 24;
   localparam int NREG  = 17;
   localparam int WD_NS = 400000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pix_in_valid = 1'b0;
   logic [PIX_W-1:0] pix_in_data = '0;
   logic        pix_in_ready, hsync_o, vsync_o, de_o, fetch_o;
   logic [PIX_W-1:0] pix_out_data;
   logic [15:0] frame_count, line_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit uflow_mode = 1'b0;
   int cyc = 0;

   always #10 clk = ~clk;

   vidtime_engine u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pix_in_valid(pix_in_valid), .pix_in_data(pix_in_data), .pix_in_ready(pix_in_ready),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_out_data(pix_out_data),
      .fetch_o(fetch_o), .frame_count(frame_count), .line_count(line_count)
   );

   // ---------------- reference model ----------------
   logic [31:0] stg [NREG];
   logic [31:0] act [NREG];
   bit  m_en = 0;
   bit [1:0] m_cen = 0;
   longint hpos = 0, fpos = 0;
   int  m_frame = 0, m_line = 0;
   bit  e_hs = 0, e_vs = 0, e_de = 0, e_fetch = 0;
   logic [PIX_W-1:0] e_pix = '0;

   function automatic bit win(longint v, longint lo, longint hi);
      return v >= lo && v <= hi;
   endfunction

   function automatic bit m_disp();
      return m_en && win(hpos, act[5][15:0], act[5][31:16]) && win(fpos, act[6], act[7]);
   endfunction

   function automatic bit m_act();
      bit h_ok, v_ok;
      h_ok = !act[1][29] || win(hpos, act[8][15:0], act[8][31:16]);
      v_ok = !act[1][30] || win(fpos, act[9], act[10]);
      return h_ok && v_ok;
   endfunction

   initial begin
      for (int i = 0; i < NREG; i++) begin
         stg[i] = '0;
         act[i] = '0;
      end
   end

   always @(posedge clk) begin
      bit hw, fw, old_en;
      logic [31:0] snap [NREG];
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            stg[i] = '0;
            act[i] = '0;
         end
         m_en = 0; m_cen = 0; hpos = 0; fpos = 0; m_frame = 0; m_line = 0;
         e_hs = 0; e_vs = 0; e_de = 0; e_fetch = 0; e_pix = '0;
      end else begin
         cyc++;
         e_hs = (m_en && hpos < act[2][15:0]) ^ act[14][0];
         e_vs = (m_en && fpos >= act[13] && fpos < longint'(act[13]) + longint'(act[4])) ^ act[14][1];
         e_de = m_disp() ^ act[14][2];
         e_fetch = m_en && act[1][31] && fpos == act[15];
         if (!m_disp()) e_pix = '0;
         else if (!m_act()) e_pix = act[11][PIX_W-1:0];
         else if (pix_in_valid) e_pix = pix_in_data;
         else e_pix = act[12][PIX_W-1:0];
         old_en = m_en;
         fw = 0;
         if (!m_en) begin
            hpos = 0; fpos = 0; m_frame = 0; m_line = 0;
         end else begin
            hw = (hpos + 1 >= act[2][31:16]);
            fw = (fpos + 1 >= act[3]);
            hpos = hw ? 0 : hpos + 1;
            fpos = fw ? 0 : fpos + 1;
            if (fw) m_line = 0;
            else if (hw && m_cen[1]) m_line = (m_line + 1) % 65536;
            if (fw && m_cen[0]) m_frame = (m_frame + 1) % 65536;
         end
         for (int i = 0; i < NREG; i++) snap[i] = stg[i];
         if (!old_en || fw)
            for (int i = 0; i < NREG; i++) act[i] = snap[i];
         if (wr_en && wr_addr[1:0] == 2'b00 && (wr_addr >> 2) < NREG) begin
            stg[wr_addr >> 2] = wr_data;
            if (wr_addr == 8'h00) m_en = wr_data[0];
            if (wr_addr == 8'h40) m_cen = wr_data[1:0];
         end
      end
   end

   task automatic check(input bit ok, input string tag, input longint actual, input longint expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, actual, expected);
      end
   endtask

   // per-cycle comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(hsync_o == e_hs, "R2 R7 R10 hsync", hsync_o, e_hs);
         check(vsync_o == e_vs, "R3 R7 vsync", vsync_o, e_vs);
         check(de_o == e_de, "R4 R7 de", de_o, e_de);
         check(pix_out_data == e_pix, "R4 R5 R6 R11 pixel", pix_out_data, e_pix);
         check(fetch_o == e_fetch, "R8 fetch", fetch_o, e_fetch);
         check(frame_count == 16'(m_frame), "R9 frame_count", frame_count, m_frame);
         check(line_count == 16'(m_line), "R9 line_count", line_count, m_line);
         check(pix_in_ready == (m_disp() && m_act()), "R11 ready", pix_in_ready, m_disp() && m_act());
      end
   end

   // upstream pixel source
   initial begin
      forever begin
         @(negedge clk);
         pix_in_valid = !uflow_mode && ((cyc % 7) != 3);
         pix_in_data  = PIX_W'(cyc * 32'h0001_0203);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(WD_NS);
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      finish_up();
   end

   initial begin
      int f0, nf;
      run(5);
      // R1: reset state
      check({hsync_o, vsync_o, de_o, fetch_o} == 4'b0, "R1 reset syncs", {hsync_o, vsync_o, de_o, fetch_o}, 0);
      check(pix_out_data == '0 && frame_count == 0 && line_count == 0, "R1 reset data", pix_out_data, 0);
      rst_n = 1'b1;
      run(2);
      // program while stopped (R10 immediate path, R12 map)
      wr(8'h08, {16'd10, 16'd2});
      wr(8'h0C, 32'd60);
      wr(8'h10, 32'd10);
      wr(8'h14, {16'd8, 16'd3});
      wr(8'h18, 32'd20);
      wr(8'h1C, 32'd49);
      wr(8'h2C, 32'h0000FF);
      wr(8'h30, 32'hFF0000);
      wr(8'h34, 32'd0);
      wr(8'h38, 32'd0);
      wr(8'h3C, 32'd5);
      wr(8'h40, 32'd3);
      wr(8'h00, 32'd1);
      run(130);
      // R10: mid-frame change of hsync width and skew, applied at the wrap
      wr(8'h08, {16'd10, 16'd4});
      wr(8'h34, 32'd3);
      run(150);
      // R5, R7, R8: active window, inverted polarity, fetch
      wr(8'h04, 32'hE000_0000);
      wr(8'h20, {16'd6, 16'd4});
      wr(8'h24, 32'd30);
      wr(8'h28, 32'd39);
      wr(8'h38, 32'd7);
      f0 = frame_count;
      while (frame_count == 16'(f0)) @(negedge clk);
      run(1);
      f0 = frame_count;
      while (frame_count == 16'(f0)) @(negedge clk);
      nf = 0;
      repeat (120) begin
         @(negedge clk);
         if (fetch_o) nf++;
      end
      check(nf == 2, "R8 fetch pulses in two frames", nf, 2);
      // R6: upstream starves
      uflow_mode = 1'b1;
      run(120);
      uflow_mode = 1'b0;
      // R9: frame counting only, then line counting only
      wr(8'h40, 32'd1);
      f0 = frame_count;
      run(70);
      check(line_count == 0, "R9 line count gated", line_count, 0);
      check(frame_count != 16'(f0), "R9 frame count advances", frame_count, f0 + 1);
      wr(8'h40, 32'd2);
      f0 = frame_count;
      run(70);
      check(frame_count == 16'(f0), "R9 frame count gated", frame_count, f0);
      // R12: writes outside the map change nothing
      wr(8'h44, 32'hFFFF_FFFF);
      wr(8'h06, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      run(130);
      // frame period not a multiple of the line period
      wr(8'h0C, 32'd57);
      run(130);
      // R1: disable, syncs idle at inverted levels
      wr(8'h00, 32'd0);
      run(2);
      check({hsync_o, vsync_o, de_o} == 3'b111, "R1 idle inverted syncs", {hsync_o, vsync_o, de_o}, 7);
      check(fetch_o == 1'b0 && pix_out_data == '0, "R1 idle data", pix_out_data, 0);
      check(frame_count == 0 && line_count == 0, "R1 idle counters", frame_count, 0);
      // R12: re-enable restarts from position zero
      wr(8'h00, 32'd1);
      run(70);
      finish_up();
   end

endmodule